// File: doc/BRIEF.md
# Atomic Read-Modify-Write Execution Unit

This unit carries out one atomic memory operation at a time. It takes a 32-bit instruction word together with the two source register values. It decodes the operation and checks the instruction and the address. It then reads the target location and combines the old value with the second operand. It writes the result back to the same location and hands the old value to the register file. A lock output stays high for the whole read-to-write window, so that the memory arbiter can keep other requesters out while the update is in flight.

The datapath width is a parameter: 32 or 64 bits. Word operations work on the low 32 bits of the memory bus. The old word is sign-extended to the full width before it is returned or combined with the operand. Bad encodings and unaligned addresses do not touch memory. Instead, the unit finishes at once with a fault flag set.

Top module: `amo_unit`

## Requirements
- R1: An instruction is accepted as legal only when bits 6:0 equal 0101111 and bits 14:12 equal 010 (word) or 011 (doubleword). Any other value finishes with `illegal` high, no memory request, and no register write.
- R2: Bits 31:27 choose the combine function: 00001 swap, 00000 add, 00100 xor, 01100 and, 01000 or, 10000 signed min, 10100 signed max, 11000 unsigned min, 11100 unsigned max. Every other value, including 00010 and 00011, is illegal.
- R3: With XLEN = 32, a doubleword encoding is illegal and makes no memory request.
- R4: A legal word operation whose address bits 1:0 are not zero, or a legal doubleword operation whose address bits 2:0 are not zero, finishes with `misaligned` high and no memory request. The two flags are never high together, and `illegal` wins.
- R5: A legal operation issues exactly one read and then exactly one write, both to the full rs1 value, with `memDword` showing the size. `memLock` is high from the cycle the read request appears until the write is accepted, and low at all other times.
- R6: `rdData` is the value read from memory. For word operations it is the sign extension of `memRdata[31:0]`, whatever the upper bus bits carry.
- R7: `rdWrEn` is high in the completion cycle only for a fault-free operation whose destination field (bits 11:7) is not zero. The memory write still happens when that field is zero.
- R8: Swap writes rs2 unchanged. Add, xor, and, or write the old value combined with rs2 by that function.
- R9: Signed min/max compare as two's complement. Unsigned min/max compare as unsigned. Min writes rs2 when the old value is greater, and max writes rs2 when the old value is smaller; otherwise the old value is written.
- R10: For word operations the operand is the sign extension of rs2 bits 31:0, and `memWdata` is the sign extension of the 32-bit result.
- R11: A memory request holds its valid, address and direction until `memReqReady`. The read data is taken on `memRespValid` after the read is accepted. `reqReady` is high only when idle, and `doneValid` is a one-cycle pulse after each accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Instruction offered |
| reqReady | output | 1 | Unit idle and accepting |
| instr | input | 32 | Instruction word |
| rs1Val | input | XLEN | Address operand |
| rs2Val | input | XLEN | Combine operand |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memWe | output | 1 | 1 = write, 0 = read |
| memDword | output | 1 | 1 = doubleword access, 0 = word |
| memAddr | output | XLEN | Access address |
| memWdata | output | XLEN | Write data |
| memRespValid | input | 1 | Read data valid |
| memRdata | input | XLEN | Read data |
| memLock | output | 1 | Hold other requesters off |
| doneValid | output | 1 | Completion pulse |
| illegal | output | 1 | Unsupported encoding |
| misaligned | output | 1 | Unaligned address |
| rdWrEn | output | 1 | Register write enable |
| rdIdx | output | 5 | Destination register |
| rdData | output | XLEN | Old memory value |

## Verification
The bench builds the main instance with XLEN = 64, which reaches both the word and the doubleword paths. The upper bus bits are filled with junk on word reads, so the sign extension of R6 and R10 is seen at the ports. A second instance with XLEN = 32 is given a doubleword encoding, which makes the R3 rejection observable. Read, response and write latencies are varied per operation, so the held requests and the lock window are seen across stalls.

// File: rtl/amo_pkg.sv
`timescale 1ns/1ps
package amo_pkg;

  typedef enum logic [3:0] {
    ALU_SWAP, ALU_ADD, ALU_XOR, ALU_AND, ALU_OR,
    ALU_MIN, ALU_MAX, ALU_MINU, ALU_MAXU
  } aluOp_e;

  typedef struct packed {
    logic   legal;
    logic   isDword;
    aluOp_e op;
  } decoded_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic captureRead;
  } strobes_t;

  localparam logic [6:0] AMO_OPCODE = 7'b0101111;
  localparam logic [2:0] SZ_WORD    = 3'b010;
  localparam logic [2:0] SZ_DWORD   = 3'b011;

  function automatic decoded_t decodeAmo(input logic [31:0] ins, input logic dwordOk);
    decoded_t d;
    d.legal   = (ins[6:0] == AMO_OPCODE);
    d.isDword = 1'b0;
    d.op      = ALU_ADD;
    case (ins[14:12])
      SZ_WORD:  d.isDword = 1'b0;
      SZ_DWORD: begin
        d.isDword = 1'b1;
        if (!dwordOk) d.legal = 1'b0;
      end
      default:  d.legal = 1'b0;
    endcase
    case (ins[31:27])
      5'b00001: d.op = ALU_SWAP;
      5'b00000: d.op = ALU_ADD;
      5'b00100: d.op = ALU_XOR;
      5'b01100: d.op = ALU_AND;
      5'b01000: d.op = ALU_OR;
      5'b10000: d.op = ALU_MIN;
      5'b10100: d.op = ALU_MAX;
      5'b11000: d.op = ALU_MINU;
      5'b11100: d.op = ALU_MAXU;
      default:  d.legal = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/amo_alu.sv
`timescale 1ns/1ps
module amo_alu
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  aluOp_e           op,
  input  logic [XLEN-1:0]  oldVal,
  input  logic [XLEN-1:0]  operand,
  output logic [XLEN-1:0]  result
);

  logic sGreater, sLess, uGreater, uLess;

  always_comb begin
    sGreater = $signed(oldVal) > $signed(operand);
    sLess    = $signed(oldVal) < $signed(operand);
    uGreater = oldVal > operand;
    uLess    = oldVal < operand;
  end

  always_comb begin
    case (op)
      ALU_SWAP: result = operand;
      ALU_ADD:  result = oldVal + operand;
      ALU_XOR:  result = oldVal ^ operand;
      ALU_AND:  result = oldVal & operand;
      ALU_OR:   result = oldVal | operand;
      ALU_MIN:  result = sGreater ? operand : oldVal;
      ALU_MAX:  result = sLess    ? operand : oldVal;
      ALU_MINU: result = uGreater ? operand : oldVal;
      ALU_MAXU: result = uLess    ? operand : oldVal;
      default:  result = operand;
    endcase
  end

endmodule

// File: rtl/amo_datapath.sv
`timescale 1ns/1ps
module amo_datapath
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  input  aluOp_e           opIn,
  input  logic             dwordIn,
  input  logic [4:0]       rdIn,
  input  logic [XLEN-1:0]  rs1Val,
  input  logic [XLEN-1:0]  rs2Val,
  input  logic [XLEN-1:0]  memRdata,
  output logic [XLEN-1:0]  memAddr,
  output logic [XLEN-1:0]  memWdata,
  output logic             memDword,
  output logic [4:0]       rdIdx,
  output logic [XLEN-1:0]  rdData,
  output logic             rdNonZero
);

  aluOp_e          opQ;
  logic            dwordQ;
  logic [4:0]      rdQ;
  logic [XLEN-1:0] addrQ, operandQ, oldQ, aluOut;

  function automatic logic [XLEN-1:0] sextWord(input logic [31:0] w);
    return XLEN'(signed'(w));
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ      <= ALU_ADD;
      dwordQ   <= 1'b0;
      rdQ      <= '0;
      addrQ    <= '0;
      operandQ <= '0;
      oldQ     <= '0;
    end else begin
      if (strobes.latchReq) begin
        opQ      <= opIn;
        dwordQ   <= dwordIn;
        rdQ      <= rdIn;
        addrQ    <= rs1Val;
        operandQ <= dwordIn ? rs2Val : sextWord(rs2Val[31:0]);
      end
      if (strobes.captureRead)
        oldQ <= dwordQ ? memRdata : sextWord(memRdata[31:0]);
    end
  end

  amo_alu #(.XLEN(XLEN)) u_alu (
    .op      (opQ),
    .oldVal  (oldQ),
    .operand (operandQ),
    .result  (aluOut)
  );

  always_comb begin
    memAddr   = addrQ;
    memWdata  = dwordQ ? aluOut : sextWord(aluOut[31:0]);
    memDword  = dwordQ;
    rdIdx     = rdQ;
    rdData    = oldQ;
    rdNonZero = (rdQ != 5'd0);
  end

endmodule

// File: rtl/amo_ctrl.sv
`timescale 1ns/1ps
module amo_ctrl
  import amo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       legal,
  input  logic       isDword,
  input  logic [2:0] addrLow,
  input  logic       memReqReady,
  input  logic       memRespValid,
  input  logic       rdNonZero,
  output logic       reqReady,
  output logic       memReqValid,
  output logic       memWe,
  output logic       memLock,
  output logic       doneValid,
  output logic       illegal,
  output logic       misaligned,
  output logic       rdWrEn,
  output strobes_t   strobes
);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_RWAIT, S_WRITE, S_DONE} state_e;

  state_e state, stateNext;
  logic   illQ, misQ, misNow;

  always_comb misNow = isDword ? (addrLow != 3'd0) : (addrLow[1:0] != 2'd0);

  always_comb begin
    stateNext = state;
    strobes   = '0;
    case (state)
      S_IDLE: if (reqValid) begin
        strobes.latchReq = 1'b1;
        stateNext = (legal && !misNow) ? S_READ : S_DONE;
      end
      S_READ:  if (memReqReady) stateNext = S_RWAIT;
      S_RWAIT: if (memRespValid) begin
        strobes.captureRead = 1'b1;
        stateNext = S_WRITE;
      end
      S_WRITE: if (memReqReady) stateNext = S_DONE;
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      illQ  <= 1'b0;
      misQ  <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && reqValid) begin
        illQ <= !legal;
        misQ <= legal && misNow;
      end
    end
  end

  always_comb begin
    reqReady    = (state == S_IDLE);
    memReqValid = (state == S_READ) || (state == S_WRITE);
    memWe       = (state == S_WRITE);
    memLock     = (state == S_READ) || (state == S_RWAIT) || (state == S_WRITE);
    doneValid   = (state == S_DONE);
    illegal     = doneValid && illQ;
    misaligned  = doneValid && misQ;
    rdWrEn      = doneValid && !illQ && !misQ && rdNonZero;
  end

  // a stalled request keeps its valid and direction
  assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memWe)));

  // every memory request lies inside the lock window
  assert_lock_covers_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memLock);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(illegal && misaligned));

  // a write request follows a cycle in which the lock was already held
  assert_write_after_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> $past(memLock));

endmodule

// File: rtl/amo_unit.sv
`timescale 1ns/1ps
module amo_unit
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [31:0]      instr,
  input  logic [XLEN-1:0]  rs1Val,
  input  logic [XLEN-1:0]  rs2Val,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic             memWe,
  output logic             memDword,
  output logic [XLEN-1:0]  memAddr,
  output logic [XLEN-1:0]  memWdata,
  input  logic             memRespValid,
  input  logic [XLEN-1:0]  memRdata,
  output logic             memLock,
  output logic             doneValid,
  output logic             illegal,
  output logic             misaligned,
  output logic             rdWrEn,
  output logic [4:0]       rdIdx,
  output logic [XLEN-1:0]  rdData
);

  localparam logic DWORD_OK = (XLEN >= 64);

  decoded_t dec;
  strobes_t strobes;
  logic     rdNonZero;

  always_comb dec = decodeAmo(instr, DWORD_OK);

  amo_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .legal        (dec.legal),
    .isDword      (dec.isDword),
    .addrLow      (rs1Val[2:0]),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .rdNonZero    (rdNonZero),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .memWe        (memWe),
    .memLock      (memLock),
    .doneValid    (doneValid),
    .illegal      (illegal),
    .misaligned   (misaligned),
    .rdWrEn       (rdWrEn),
    .strobes      (strobes)
  );

  amo_datapath #(.XLEN(XLEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .opIn      (dec.op),
    .dwordIn   (dec.isDword),
    .rdIn      (instr[11:7]),
    .rs1Val    (rs1Val),
    .rs2Val    (rs2Val),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memDword  (memDword),
    .rdIdx     (rdIdx),
    .rdData    (rdData),
    .rdNonZero (rdNonZero)
  );

  // writeback only on a clean completion toward a nonzero register
  assert_writeback_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdWrEn |-> (doneValid && rdIdx != 5'd0 && !illegal && !misaligned));

endmodule

// File: tb/amo_unit_tb.sv
`timescale 1ns/1ps
module amo_unit_tb;

  localparam int XL = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic          reqValid = 1'b0, reqReady;
  logic [31:0]   instr = '0;
  logic [XL-1:0] rs1Val = '0, rs2Val = '0;
  logic          memReqValid, memReqReady = 1'b0, memWe, memDword;
  logic [XL-1:0] memAddr, memWdata;
  logic          memRespValid = 1'b0;
  logic [XL-1:0] memRdata = '0;
  logic          memLock, doneValid, illegal, misaligned, rdWrEn;
  logic [4:0]    rdIdx;
  logic [XL-1:0] rdData;

  amo_unit #(.XLEN(XL)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .instr(instr), .rs1Val(rs1Val), .rs2Val(rs2Val),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memWe(memWe),
    .memDword(memDword), .memAddr(memAddr), .memWdata(memWdata),
    .memRespValid(memRespValid), .memRdata(memRdata), .memLock(memLock),
    .doneValid(doneValid), .illegal(illegal), .misaligned(misaligned),
    .rdWrEn(rdWrEn), .rdIdx(rdIdx), .rdData(rdData)
  );

  // narrow instance for the 32-bit variant
  logic        reqValid32 = 1'b0, reqReady32;
  logic [31:0] instr32 = '0, rs1Val32 = '0, rs2Val32 = '0;
  logic        memReqValid32, memWe32, memDword32, memLock32;
  logic [31:0] memAddr32, memWdata32, rdData32;
  logic        doneValid32, illegal32, misaligned32, rdWrEn32;
  logic [4:0]  rdIdx32;

  amo_unit #(.XLEN(32)) u_dut32 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid32), .reqReady(reqReady32),
    .instr(instr32), .rs1Val(rs1Val32), .rs2Val(rs2Val32),
    .memReqValid(memReqValid32), .memReqReady(1'b0), .memWe(memWe32),
    .memDword(memDword32), .memAddr(memAddr32), .memWdata(memWdata32),
    .memRespValid(1'b0), .memRdata(32'h0), .memLock(memLock32),
    .doneValid(doneValid32), .illegal(illegal32), .misaligned(misaligned32),
    .rdWrEn(rdWrEn32), .rdIdx(rdIdx32), .rdData(rdData32)
  );

  int checks = 0;
  int errors = 0;
  logic [63:0] mem [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] f5, input logic [2:0] f3,
                                     input logic [4:0] rd);
    return {f5, 2'b00, 5'd2, 5'd1, f3, rd, 7'b0101111};
  endfunction

  function automatic logic [63:0] sx(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  // behavioural reference for one operation, run against the DUT cycle by cycle
  task automatic runOp(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                       input int rLat, input int pLat, input int wLat);
    logic [4:0] f5 = ins[31:27];
    logic [2:0] f3 = ins[14:12];
    bit isD = (f3 == 3'b011);
    bit f5ok = (f5 inside {5'b00001, 5'b00000, 5'b00100, 5'b01100, 5'b01000,
                           5'b10000, 5'b10100, 5'b11000, 5'b11100});
    bit expIll = (ins[6:0] != 7'b0101111) || !(f3 == 3'b010 || isD) || !f5ok;
    bit expMis = !expIll && (isD ? (a[2:0] != 0) : (a[1:0] != 0));
    bit fault = expIll || expMis;
    int idx = int'(a[6:3]);
    logic [63:0] old, opnd, res, expW, busData;
    bit rdAcc = 0, respDone = 0, wrAcc = 0, fin = 0;
    bit drRd = 0, drResp = 0, drWr = 0;
    int waitCnt = 0;
    logic [63:0] wSeen = '0;

    if (isD) begin
      old = mem[idx]; busData = old; opnd = b;
    end else begin
      old = sx(a[2] ? mem[idx][63:32] : mem[idx][31:0]);
      busData = {32'hA5C3_3C5A, old[31:0]};
      opnd = sx(b[31:0]);
    end
    case (f5)
      5'b00001: res = opnd;
      5'b00000: res = old + opnd;
      5'b00100: res = old ^ opnd;
      5'b01100: res = old & opnd;
      5'b01000: res = old | opnd;
      5'b10000: res = ($signed(old) > $signed(opnd)) ? opnd : old;
      5'b10100: res = ($signed(old) < $signed(opnd)) ? opnd : old;
      5'b11000: res = (old > opnd) ? opnd : old;
      default:  res = (old < opnd) ? opnd : old;
    endcase
    expW = isD ? res : sx(res[31:0]);

    @(negedge clk);
    chk(reqReady, "R11", "reqReady when idle", {63'd0, reqReady}, 64'd1);
    reqValid = 1'b1; instr = ins; rs1Val = a; rs2Val = b;

    for (int cyc = 0; cyc < 60 && !fin; cyc++) begin
      @(negedge clk);
      reqValid = 1'b0; memReqReady = 1'b0; memRespValid = 1'b0; memRdata = '0;
      if (drRd) rdAcc = 1;
      if (drResp) respDone = 1;
      if (drWr) begin
        wrAcc = 1;
        if (isD) mem[idx] = wSeen;
        else if (a[2]) mem[idx][63:32] = wSeen[31:0];
        else mem[idx][31:0] = wSeen[31:0];
      end
      drRd = 0; drResp = 0; drWr = 0;

      chk(memLock == (!fault && !wrAcc), "R5", "lock window", {63'd0, memLock},
          {63'd0, (!fault && !wrAcc)});
      if (!doneValid)
        chk(!reqReady, "R11", "busy not ready", {63'd0, reqReady}, 64'd0);

      if (doneValid) begin
        fin = 1;
        chk(illegal == expIll, expIll ? "R1/R2" : "R1", "illegal flag",
            {63'd0, illegal}, {63'd0, expIll});
        chk(misaligned == expMis, "R4", "misaligned flag", {63'd0, misaligned},
            {63'd0, expMis});
        chk(rdWrEn == (!fault && ins[11:7] != 0), "R7", "rdWrEn", {63'd0, rdWrEn},
            {63'd0, (!fault && ins[11:7] != 0)});
        chk(fault || wrAcc, "R5", "write before done", {63'd0, wrAcc}, 64'd1);
        if (!fault) begin
          chk(rdData == old, "R6", "old value", rdData, old);
          if (ins[11:7] != 0) chk(rdIdx == ins[11:7], "R7", "rd index", 64'(rdIdx), 64'(ins[11:7]));
        end
      end else if (memReqValid && !memWe) begin
        chk(!fault && !rdAcc, fault ? "R4" : "R5", "unexpected read", 64'd1, 64'd0);
        chk(memAddr == a && memDword == isD, "R5", "read addr", memAddr, a);
        if (waitCnt >= rLat) begin memReqReady = 1'b1; drRd = 1; waitCnt = 0; end
        else waitCnt++;
      end else if (rdAcc && !respDone) begin
        chk(!memReqValid, "R11", "no request while awaiting data", {63'd0, memReqValid}, 64'd0);
        if (waitCnt >= pLat) begin
          memRespValid = 1'b1; memRdata = busData; drResp = 1; waitCnt = 0;
        end else waitCnt++;
      end else if (memReqValid && memWe) begin
        chk(respDone && !wrAcc, "R5", "write order", {63'd0, respDone}, 64'd1);
        chk(memAddr == a && memDword == isD, "R5", "write addr", memAddr, a);
        chk(memWdata == expW, (f5 inside {5'b10000, 5'b10100, 5'b11000, 5'b11100}) ? "R9" :
            (isD ? "R8" : "R10"), "write data", memWdata, expW);
        if (waitCnt >= wLat) begin memReqReady = 1'b1; drWr = 1; wSeen = memWdata; waitCnt = 0; end
        else waitCnt++;
      end else if (memReqValid) begin
        chk(0, "R5", "stray request", 64'd1, 64'd0);
      end
    end
    chk(fin, "R11", "completion seen", {63'd0, fin}, 64'd1);
    @(negedge clk);
    chk(!doneValid, "R11", "done is one pulse", {63'd0, doneValid}, 64'd0);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=hang expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++)
      mem[i] = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h1111_0000_0101_0011);
    mem[2] = 64'hFFFF_FFFF_8000_0005;
    mem[3] = 64'h8000_0000_0000_0010;

    repeat (3) @(negedge clk);
    chk(reqReady && !memReqValid && !memLock && !doneValid, "R11", "reset state",
        {60'd0, reqReady, memReqValid, memLock, doneValid}, 64'h8);
    rstN = 1'b1;

    // R8 arithmetic and bitwise
    runOp(mk(5'b00000, 3'b011, 5'd5), 64'h18, 64'h0000_0001_0000_0001, 0, 0, 0);
    runOp(mk(5'b00001, 3'b010, 5'd6), 64'h14, 64'h0000_0000_9000_0000, 2, 1, 1);
    runOp(mk(5'b00100, 3'b011, 5'd7), 64'h20, 64'hFFFF_0000_FFFF_0000, 1, 3, 0);
    runOp(mk(5'b01100, 3'b010, 5'd8), 64'h28, 64'h1234_5678_F0F0_F0F0, 0, 0, 2);
    runOp(mk(5'b01000, 3'b011, 5'd9), 64'h30, 64'h8000_0000_0000_0001, 0, 1, 0);
    // R9 compares, R10 word sign behaviour
    runOp(mk(5'b10000, 3'b010, 5'd10), 64'h10, 64'h0000_0000_0000_0003, 0, 0, 0);
    runOp(mk(5'b10100, 3'b011, 5'd11), 64'h18, 64'h7FFF_0000_0000_0000, 1, 0, 1);
    runOp(mk(5'b11000, 3'b011, 5'd12), 64'h18, 64'h0000_0000_0000_0020, 0, 2, 0);
    runOp(mk(5'b11100, 3'b010, 5'd13), 64'h14, 64'h0000_0000_0000_0001, 0, 0, 0);
    runOp(mk(5'b11100, 3'b010, 5'd13), 64'h3C, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0);
    runOp(mk(5'b10000, 3'b011, 5'd14), 64'h40, 64'h8000_0000_0000_0000, 0, 0, 0);
    // R7 destination zero still writes, then read back through swap
    runOp(mk(5'b00000, 3'b010, 5'd0), 64'h48, 64'h0000_0000_0000_0100, 1, 1, 1);
    runOp(mk(5'b00001, 3'b010, 5'd3), 64'h48, 64'h0, 0, 0, 0);
    // R1 / R2 illegal encodings
    runOp(mk(5'b00000, 3'b011, 5'd4) ^ 32'h1, 64'h10, 64'h0, 0, 0, 0);
    runOp(mk(5'b00000, 3'b000, 5'd4), 64'h10, 64'h0, 0, 0, 0);
    runOp(mk(5'b00010, 3'b010, 5'd4), 64'h10, 64'h0, 0, 0, 0);
    runOp(mk(5'b00011, 3'b011, 5'd4), 64'h10, 64'h0, 0, 0, 0);
    runOp(mk(5'b11111, 3'b010, 5'd4), 64'h10, 64'h0, 0, 0, 0);
    // R4 misaligned, and illegal beating misaligned
    runOp(mk(5'b00000, 3'b010, 5'd4), 64'h12, 64'h1, 0, 0, 0);
    runOp(mk(5'b00000, 3'b011, 5'd4), 64'h14, 64'h1, 0, 0, 0);
    runOp(mk(5'b00110, 3'b011, 5'd4), 64'h13, 64'h1, 0, 0, 0);

    // R3 doubleword rejected at XLEN = 32
    @(negedge clk);
    reqValid32 = 1'b1; instr32 = mk(5'b00000, 3'b011, 5'd5); rs1Val32 = 32'h10;
    @(negedge clk);
    reqValid32 = 1'b0;
    chk(doneValid32 && illegal32 && !misaligned32 && !rdWrEn32, "R3", "dword illegal on 32",
        {60'd0, doneValid32, illegal32, misaligned32, rdWrEn32}, 64'hC);
    chk(!memReqValid32 && !memLock32, "R3", "no access on 32",
        {62'd0, memReqValid32, memLock32}, 64'd0);
    @(negedge clk);
    chk(!memReqValid32 && reqReady32, "R3", "idle after reject",
        {62'd0, memReqValid32, reqReady32}, 64'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule